// File: doc/BRIEF.md
# Auto-Increment Word Programming Sequencer

This block is an SPI host engine that writes a run of 16-bit words into a serial flash using the device's auto-address-increment word programming. A client pulses `start` with an even byte address and a word count. The sequencer first sends a write-enable frame. It then asks the client for one word at a time through a request/valid handshake. The first word goes out in a frame that carries the address. Every later word goes out in a short frame that carries only the two data bytes. After each program frame the engine polls the device status register in one chip-select window until the busy bit clears. When the last word is done it sends write-disable, pulses `done` and drops `busy`.

The serial link is SPI mode 0. SCK idles low, the host shifts data out on falling edges and samples MISO on rising edges, and every byte goes out MSB first. The SCK half period and the minimum chip-select high time between frames are both parameters, counted in system clocks.

Top module: `aai_word_writer`

## Requirements
- R1: Out of reset, `csN` is high, `sck` is low, and `busy`, `done`, `addrErr` and `wordReq` are low.
- R2: A `start` with an odd `startAddr` (bit 0 set) gives `done` and `addrErr` high together for one cycle, in the cycle after `start` is sampled. No frame is sent, no word is requested and `busy` stays low.
- R3: A `start` with an even address and `wordCount` of 0 gives a one-cycle `done` with `addrErr` low, in the cycle after `start` is sampled. No frame is sent.
- R4: An accepted run begins with a one-byte frame holding opcode 06h.
- R5: The first word goes out in a frame of opcode ADh, then the address bytes most significant first, then `wordData[7:0]` (even byte address), then `wordData[15:8]` (odd byte address).
- R6: Every later word goes out in a three-byte frame: ADh, `wordData[7:0]`, `wordData[15:8]`, with no address bytes.
- R7: After each program frame, one frame sends opcode 05h and then reads status bytes (sending 00h) until a status byte has bit 0 clear. No program frame is sent while the device still reports busy.
- R8: After the poll that follows the last word, the run ends with a one-byte frame holding opcode 04h.
- R9: `sck` is low whenever `csN` is high, and each frame holds a whole number of 8-clock bytes.
- R10: `csN` stays high for at least `CS_GAP` system clocks between any two frames.
- R11: `wordReq` stays high until `wordValid` is seen with it. Exactly one word is taken for each program frame, and exactly `wordCount` words are taken per run.
- R12: `busy` rises in the cycle after an accepted `start` and stays high until the single-cycle `done` that follows the write-disable frame. `busy` is low in the `done` cycle. A `start` while `busy` is high is ignored.
- R13: Each SCK phase (high or low) within a byte lasts `CLK_DIV` system clocks, so rising edges within a byte are `2*CLK_DIV` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| startAddr | input | 8*ADDR_BYTES | Byte address of the first word; must be even |
| wordCount | input | CNT_W | Number of 16-bit words to write |
| wordReq | output | 1 | Sequencer wants the next word |
| wordValid | input | 1 | `wordData` is valid; taken while `wordReq` is high |
| wordData | input | 16 | Word to program; low byte goes to the even address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run (or rejection) pulse |
| addrErr | output | 1 | One-cycle pulse with `done` when the start address is odd |
| sck | output | 1 | SPI serial clock, idles low |
| csN | output | 1 | Active-low flash chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Rejections and zero-length runs are sampled at the falling clock edge just after the rising edge that took `start`, because `done`, `addrErr` and `busy` are registered once at that edge. `busy` is checked at that same point for accepted runs. The serial results are due at no fixed cycle, because they depend on the word latency and on how many busy status bytes the flash model returns. So a behavioural flash model in the bench decodes every frame at the SCK and chip-select edges, logs its bytes, and measures chip-select gaps and SCK spacing in system clocks. The log is compared against the frame list expected from the requirements once `done` is seen. The flash model updates MISO on SCK falling edges, a full half period before the sequencer samples it.

// File: rtl/aww_pkg.sv
`timescale 1ns/1ps
package aww_pkg;

  localparam logic [7:0] OP_WR_ON   = 8'h06;
  localparam logic [7:0] OP_WR_OFF  = 8'h04;
  localparam logic [7:0] OP_AAI     = 8'hAD;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] FILL_BYTE  = 8'h00;
  localparam int         BUSY_BIT   = 0;

  typedef enum logic [2:0] {
    FR_WR_ON,
    FR_FIRST,
    FR_NEXT,
    FR_POLL,
    FR_WR_OFF
  } frameKind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SHIFT,
    S_GAP,
    S_FETCH
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       csLow;
    logic       go;
    logic [7:0] txByte;
  } dpCmd_t;

  // datapath -> control report
  typedef struct packed {
    logic       byteDone;
    logic [7:0] rxByte;
  } dpStat_t;

endpackage

// File: rtl/aww_shift.sv
`timescale 1ns/1ps
module aww_shift
  import aww_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    sck,
  output logic    csN,
  output logic    mosi,
  input  logic    miso
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic             sckReg;
  logic [7:0]       shTx;
  logic [7:0]       shRx;
  logic             doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      sckReg <= 1'b0;
      shTx   <= '0;
      shRx   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!active) begin
        if (cmd.go) begin
          active <= 1'b1;
          shTx   <= cmd.txByte;
          divCnt <= '0;
          bitCnt <= '0;
          sckReg <= 1'b0;
        end
      end else if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        if (!sckReg) begin
          // rising edge: sample the device
          sckReg <= 1'b1;
          shRx   <= {shRx[6:0], miso};
        end else begin
          // falling edge: present the next bit
          sckReg <= 1'b0;
          shTx   <= {shTx[6:0], 1'b0};
          if (bitCnt == 3'd7) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 3'd1;
          end
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign stat.byteDone = doneQ;
  assign stat.rxByte   = shRx;
  assign sck           = sckReg;
  assign mosi          = shTx[7];
  assign csN           = ~cmd.csLow;

endmodule

// File: rtl/aww_ctrl.sv
`timescale 1ns/1ps
module aww_ctrl
  import aww_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 16,
  parameter int CS_GAP     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] startAddr,
  input  logic [CNT_W-1:0]        wordCount,
  output logic                    wordReq,
  input  logic                    wordValid,
  input  logic [15:0]             wordData,
  output logic                    busy,
  output logic                    done,
  output logic                    addrErr,
  output dpCmd_t                  cmd,
  input  dpStat_t                 stat
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IDX_W  = $clog2(ADDR_BYTES + 3);
  localparam int GAP_W  = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [IDX_W-1:0] FIRST_LAST = IDX_W'(ADDR_BYTES + 2);
  localparam logic [IDX_W-1:0] NEXT_LAST  = IDX_W'(2);
  localparam logic [IDX_W-1:0] LO_IDX     = IDX_W'(ADDR_BYTES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST   = GAP_W'(CS_GAP - 1);

  seqState_t          state;
  frameKind_t         kind;
  logic [IDX_W-1:0]   byteIdx;
  logic [IDX_W-1:0]   lastIdx;
  logic [ADDR_W-1:0]  addrQ;
  logic [ADDR_W-1:0]  addrShift;
  logic [15:0]        dataQ;
  logic [CNT_W-1:0]   remain;
  logic               isFirst;
  logic [GAP_W-1:0]   gapCnt;
  logic               csLow;
  logic [7:0]         txByte;

  // index of the final byte of each fixed-length frame
  always_comb begin
    case (kind)
      FR_FIRST: lastIdx = FIRST_LAST;
      FR_NEXT:  lastIdx = NEXT_LAST;
      default:  lastIdx = '0;
    endcase
  end

  // byte selection for the frame being sent
  always_comb begin
    addrShift = addrQ >> (8 * (ADDR_BYTES - int'(byteIdx)));
    txByte    = FILL_BYTE;
    case (kind)
      FR_WR_ON:  txByte = OP_WR_ON;
      FR_WR_OFF: txByte = OP_WR_OFF;
      FR_POLL:   txByte = (byteIdx == '0) ? OP_STATUS : FILL_BYTE;
      FR_FIRST: begin
        if (byteIdx == '0)          txByte = OP_AAI;
        else if (byteIdx < LO_IDX)  txByte = addrShift[7:0];
        else if (byteIdx == LO_IDX) txByte = dataQ[7:0];
        else                        txByte = dataQ[15:8];
      end
      FR_NEXT: begin
        if (byteIdx == '0)              txByte = OP_AAI;
        else if (byteIdx == IDX_W'(1))  txByte = dataQ[7:0];
        else                            txByte = dataQ[15:8];
      end
      default: txByte = FILL_BYTE;
    endcase
  end

  always_comb begin
    cmd.csLow  = csLow;
    cmd.go     = (state == S_LOAD);
    cmd.txByte = txByte;
  end

  assign wordReq = (state == S_FETCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kind    <= FR_WR_ON;
      byteIdx <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
      remain  <= '0;
      isFirst <= 1'b0;
      gapCnt  <= '0;
      csLow   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      addrErr <= 1'b0;
    end else begin
      done    <= 1'b0;
      addrErr <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (startAddr[0]) begin
              done    <= 1'b1;
              addrErr <= 1'b1;
            end else if (wordCount == '0) begin
              done <= 1'b1;
            end else begin
              busy    <= 1'b1;
              addrQ   <= startAddr;
              remain  <= wordCount;
              isFirst <= 1'b1;
              kind    <= FR_WR_ON;
              byteIdx <= '0;
              csLow   <= 1'b1;
              state   <= S_LOAD;
            end
          end
        end

        S_LOAD: state <= S_SHIFT;

        S_SHIFT: begin
          if (stat.byteDone) begin
            if (kind == FR_POLL && byteIdx != '0) begin
              if (!stat.rxByte[BUSY_BIT]) begin
                csLow  <= 1'b0;
                gapCnt <= '0;
                state  <= S_GAP;
              end else begin
                state <= S_LOAD;
              end
            end else if (kind != FR_POLL && byteIdx == lastIdx) begin
              csLow  <= 1'b0;
              gapCnt <= '0;
              state  <= S_GAP;
            end else begin
              byteIdx <= byteIdx + IDX_W'(1);
              state   <= S_LOAD;
            end
          end
        end

        S_GAP: begin
          if (gapCnt == GAP_LAST) begin
            case (kind)
              FR_WR_ON: state <= S_FETCH;
              FR_FIRST, FR_NEXT: begin
                kind    <= FR_POLL;
                byteIdx <= '0;
                csLow   <= 1'b1;
                remain  <= remain - CNT_W'(1);
                isFirst <= 1'b0;
                state   <= S_LOAD;
              end
              FR_POLL: begin
                if (remain == '0) begin
                  kind    <= FR_WR_OFF;
                  byteIdx <= '0;
                  csLow   <= 1'b1;
                  state   <= S_LOAD;
                end else begin
                  state <= S_FETCH;
                end
              end
              default: begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= S_IDLE;
              end
            endcase
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end

        S_FETCH: begin
          if (wordValid) begin
            dataQ   <= wordData;
            kind    <= isFirst ? FR_FIRST : FR_NEXT;
            byteIdx <= '0;
            csLow   <= 1'b1;
            state   <= S_LOAD;
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aai_word_writer.sv
`timescale 1ns/1ps
module aai_word_writer
  import aww_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int CS_GAP     = 3,
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] startAddr,
  input  logic [CNT_W-1:0]        wordCount,
  output logic                    wordReq,
  input  logic                    wordValid,
  input  logic [15:0]             wordData,
  output logic                    busy,
  output logic                    done,
  output logic                    addrErr,
  output logic                    sck,
  output logic                    csN,
  output logic                    mosi,
  input  logic                    miso
);

  dpCmd_t  dpCmd;
  dpStat_t dpStat;

  aww_ctrl #(
    .ADDR_BYTES(ADDR_BYTES),
    .CNT_W     (CNT_W),
    .CS_GAP    (CS_GAP)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .startAddr(startAddr),
    .wordCount(wordCount),
    .wordReq  (wordReq),
    .wordValid(wordValid),
    .wordData (wordData),
    .busy     (busy),
    .done     (done),
    .addrErr  (addrErr),
    .cmd      (dpCmd),
    .stat     (dpStat)
  );

  aww_shift #(
    .CLK_DIV(CLK_DIV)
  ) u_shift (
    .clk (clk),
    .rstN(rstN),
    .cmd (dpCmd),
    .stat(dpStat),
    .sck (sck),
    .csN (csN),
    .mosi(mosi),
    .miso(miso)
  );

endmodule

// File: rtl/aww_checker.sv
`timescale 1ns/1ps
module aww_checker #(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 3
) (
  input logic clk,
  input logic rstN,
  input logic wordReq,
  input logic wordValid,
  input logic busy,
  input logic done,
  input logic addrErr,
  input logic sck,
  input logic csN
);

  localparam int GW = $clog2(CS_GAP + 1);
  localparam int DW = $clog2(CLK_DIV + 1);

  logic [GW-1:0] highCnt;
  logic [DW-1:0] runLen;
  logic          sckQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= GW'(CS_GAP);
      runLen  <= DW'(CLK_DIV);
      sckQ    <= 1'b0;
    end else begin
      sckQ <= sck;
      if (!csN)                     highCnt <= '0;
      else if (highCnt != GW'(CS_GAP)) highCnt <= highCnt + GW'(1);
      if (sck != sckQ)              runLen <= DW'(1);
      else if (runLen != DW'(CLK_DIV)) runLen <= runLen + DW'(1);
    end
  end

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> highCnt >= GW'(CS_GAP));

  p_half_period_r13: assert property (@(posedge clk) disable iff (!rstN)
    (sck != sckQ) |-> runLen >= DW'(CLK_DIV));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  p_idle_cs_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  p_err_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (done && !busy));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wordReq && !wordValid) |=> wordReq);

  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    wordReq |-> (busy && csN));

endmodule

bind aai_word_writer aww_checker #(
  .CLK_DIV(CLK_DIV),
  .CS_GAP (CS_GAP)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wordReq  (wordReq),
  .wordValid(wordValid),
  .busy     (busy),
  .done     (done),
  .addrErr  (addrErr),
  .sck      (sck),
  .csN      (csN)
);

// File: tb/tb_aai_word_writer.sv
`timescale 1ns/1ps
module tb_aai_word_writer;

  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] startAddr = '0;
  logic [15:0] wordCount = '0;
  logic        wordReq;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        busy, done, addrErr, sck, csN, mosi;
  logic        miso = 1'b0;

  aai_word_writer #(
    .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .ADDR_BYTES(3), .CNT_W(16)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .wordCount(wordCount), .wordReq(wordReq), .wordValid(wordValid),
    .wordData(wordData), .busy(busy), .done(done), .addrErr(addrErr),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit logEn   = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc++;

  // ---------------- flash model ----------------
  int         nFrames = 0;
  int         fLen [0:63];
  logic [7:0] fB   [0:63][0:7];
  logic [7:0] frm  [0:7];
  int         busySched [0:63];
  int         progCnt = 0;
  int         busyLeft = 0;
  int         gapViol = 0, periodErr = 0, partialCnt = 0, aaiBusy = 0;
  int         bitIdx = 0, byteNo = 0, riseCyc = 0, lastRise = 0;
  bit         seenRise = 1'b0;
  logic [7:0] curByte = '0, stVal = '0;
  logic       prevCs = 1'b1, prevSck = 1'b0;

  always @(csN or sck) begin
    if (logEn) begin
      if (prevCs === 1'b1 && csN === 1'b0) begin
        if (seenRise && (cyc - riseCyc) < CS_GAP) gapViol++;
        bitIdx = 0; byteNo = 0; curByte = '0;
        for (int k = 0; k < 8; k++) frm[k] = '0;
      end else if (prevCs === 1'b0 && csN === 1'b1) begin
        if (bitIdx != 0) partialCnt++;
        if (nFrames < 64) begin
          fLen[nFrames] = byteNo;
          for (int k = 0; k < 8; k++) fB[nFrames][k] = frm[k];
        end
        nFrames++;
        if (byteNo > 0 && frm[0] == 8'hAD) begin
          busyLeft = busySched[progCnt];
          progCnt++;
        end
        riseCyc = cyc; seenRise = 1'b1;
      end else if (csN === 1'b0 && prevSck === 1'b0 && sck === 1'b1) begin
        if (bitIdx != 0 && (cyc - lastRise) != 2 * CLK_DIV) periodErr++;
        lastRise = cyc;
        curByte = {curByte[6:0], mosi};
        bitIdx++;
        if (bitIdx == 8) begin
          if (byteNo < 8) frm[byteNo] = curByte;
          if (byteNo == 0 && curByte == 8'hAD && busyLeft > 0) aaiBusy++;
          if (byteNo >= 1 && frm[0] == 8'h05 && busyLeft > 0) busyLeft--;
          byteNo++;
          bitIdx = 0;
        end
      end else if (csN === 1'b0 && prevSck === 1'b1 && sck === 1'b0) begin
        if (byteNo >= 1 && frm[0] == 8'h05) begin
          if (bitIdx == 0) stVal = (busyLeft > 0) ? 8'h03 : 8'h02;
          miso = stVal[7 - bitIdx];
        end
      end
    end
    prevCs = csN; prevSck = sck;
  end

  // ---------------- word supplier ----------------
  logic [15:0] words [0:15];
  int          wIdx = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (wordReq && !wordValid) begin
        repeat (wIdx % 3) @(negedge clk);
        wordData  = words[wIdx % 16];
        wordValid = 1'b1;
        wIdx++;
        @(negedge clk);
        wordValid = 1'b0;
      end
    end
  end

  // ---------------- output monitors ----------------
  int doneCnt = 0, errCnt = 0;
  always @(negedge clk) begin
    if (done)    doneCnt++;
    if (addrErr) errCnt++;
  end

  // ---------------- expected frames ----------------
  int         expN = 0;
  int         expLen [0:63];
  logic [7:0] expB   [0:63][0:7];

  task automatic expFrame(input int len, input logic [63:0] bytes);
    expLen[expN] = len;
    for (int k = 0; k < 8; k++) expB[expN][k] = bytes[63 - 8*k -: 8];
    expN++;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int i);
    if (expB[i][0] == 8'h06) return "R4";
    if (expB[i][0] == 8'h04) return "R8";
    if (expB[i][0] == 8'h05) return "R7";
    if (expLen[i] == 6)      return "R5";
    return "R6";
  endfunction

  task automatic compareLog(input int base);
    chk(nFrames - base == expN, "R4", "frame count", nFrames - base, expN);
    for (int i = 0; i < expN && (base + i) < nFrames; i++) begin
      chk(fLen[base+i] == expLen[i], tagOf(i), "frame length",
          fLen[base+i], expLen[i]);
      for (int k = 0; k < 8 && k < expLen[i]; k++)
        chk(fB[base+i][k] == expB[i][k], tagOf(i), "frame byte",
            fB[base+i][k], expB[i][k]);
    end
  endtask

  // run a full program sequence and check everything at the ports
  task automatic runProgram(input logic [23:0] addr, input int count,
                            input bit poke);
    int base, wBase, dBase, eBase, gBase, pBase, qBase, aBase, n;
    base = nFrames; wBase = wIdx; dBase = doneCnt; eBase = errCnt;
    gBase = gapViol; pBase = periodErr; qBase = partialCnt; aBase = aaiBusy;
    expN = 0;
    expFrame(1, 64'h06 << 56);
    for (int i = 0; i < count; i++) begin
      if (i == 0)
        expFrame(6, {8'hAD, addr, words[i][7:0], words[i][15:8], 16'h0});
      else
        expFrame(3, {8'hAD, words[i][7:0], words[i][15:8], 40'h0});
      expFrame(2 + busySched[progCnt + i], {8'h05, 56'h0});
    end
    expFrame(1, 64'h04 << 56);

    @(negedge clk);
    start = 1'b1; startAddr = addr; wordCount = 16'(count);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12", "busy after start", busy, 1);
    n = 0;
    while (!done && n < 50000) begin
      @(negedge clk);
      n++;
      if (poke && n == 150) begin start = 1'b1; startAddr = 24'h000777; end
      else start = 1'b0;
      if (!done && !busy) begin
        chk(1'b0, "R12", "busy dropped early", busy, 1);
        break;
      end
    end
    start = 1'b0;
    chk(done == 1'b1, "R12", "done seen", done, 1);
    chk(busy == 1'b0, "R12", "busy low with done", busy, 0);
    chk(addrErr == 1'b0, "R12", "no error on good run", addrErr, 0);
    @(negedge clk);
    chk(done == 1'b0, "R12", "done is one cycle", done, 0);
    repeat (10) @(negedge clk);
    chk(doneCnt - dBase == 1, "R12", "done pulses", doneCnt - dBase, 1);
    chk(errCnt == eBase, "R12", "ignored start raised no error", errCnt - eBase, 0);
    compareLog(base);
    chk(wIdx - wBase == count, "R11", "words taken", wIdx - wBase, count);
    chk(gapViol == gBase, "R10", "short csN gaps", gapViol - gBase, 0);
    chk(periodErr == pBase, "R13", "sck period errors", periodErr - pBase, 0);
    chk(partialCnt == qBase, "R9", "partial bytes", partialCnt - qBase, 0);
    chk(aaiBusy == aBase, "R7", "program while busy", aaiBusy - aBase, 0);
  endtask

  task automatic t_reset;
    chk(csN == 1'b1, "R1", "csN", csN, 1);
    chk(sck == 1'b0, "R1", "sck", sck, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(addrErr == 1'b0, "R1", "addrErr", addrErr, 0);
    chk(wordReq == 1'b0, "R1", "wordReq", wordReq, 0);
  endtask

  task automatic t_oddAddr;
    int base, wBase;
    base = nFrames; wBase = wIdx;
    @(negedge clk);
    start = 1'b1; startAddr = 24'h000123; wordCount = 16'd2;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2", "done on odd address", done, 1);
    chk(addrErr == 1'b1, "R2", "addrErr on odd address", addrErr, 1);
    chk(busy == 1'b0, "R2", "busy stays low", busy, 0);
    @(negedge clk);
    chk(addrErr == 1'b0, "R2", "addrErr one cycle", addrErr, 0);
    repeat (30) @(negedge clk);
    chk(nFrames == base, "R2", "no frames", nFrames - base, 0);
    chk(wIdx == wBase, "R2", "no words taken", wIdx - wBase, 0);
  endtask

  task automatic t_zeroCount;
    int base;
    base = nFrames;
    @(negedge clk);
    start = 1'b1; startAddr = 24'h000100; wordCount = 16'd0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R3", "done on zero count", done, 1);
    chk(addrErr == 1'b0, "R3", "no error on zero count", addrErr, 0);
    repeat (30) @(negedge clk);
    chk(nFrames == base, "R3", "no frames", nFrames - base, 0);
  endtask

  task automatic t_singleWord;
    words[0] = 16'hBEEF;
    busySched[progCnt] = 2;
    runProgram(24'h001000, 1, 1'b0);
  endtask

  task automatic t_multiWord;
    words[0] = 16'hA501; words[1] = 16'h5A02;
    words[2] = 16'hC303; words[3] = 16'h3C04;
    busySched[progCnt]     = 0;
    busySched[progCnt + 1] = 1;
    busySched[progCnt + 2] = 3;
    busySched[progCnt + 3] = 0;
    runProgram(24'h0ABCDE, 4, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) busySched[i] = 0;
    for (int i = 0; i < 16; i++) words[i] = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    logEn = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_oddAddr();
    t_zeroCount();
    t_singleWord();
    wIdx = 0;
    t_multiWord();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule